// File: doc/BRIEF.md
# Bus Write-Match Test Counter

This block is a small register target that helps software measure how many bus writes reach a chosen address. It has two byte-wide windows that share one control engine: a memory window and an I/O window. Software starts a test by writing a code to offset 0 of either window. This selects one of six tests, three per window. The block then counts writes that land on that test's trigger offset. Depending on the test, it counts every such write or only those whose data and size match a fixed pattern.

Software can read back every byte of the active test's descriptor: its index, access width, trigger offset, pattern, live 32-bit count and a NUL-terminated name. Each counted write of a notifying test kind also raises a one-cycle notify pulse, which can feed a doorbell or event path.

Top module: `wmatch_ctr`

## Requirements
- R1: After reset no test is active, every read returns 0x00 and notify is low.
- R2: A write to offset 0 of either window first deactivates the current test. If the written value v is 0, 1 or 2, test index window*3+v becomes active, where the memory window is win_sel=0 and the I/O window is win_sel=1. Any larger value leaves no test active.
- R3: Activating a test clears its count to zero in the same clock edge as the write.
- R4: The offset is addr masked to the window span: 12 bits for memory, 8 bits for I/O. Test i triggers on offset 2048+i for i=0..2 and on offset 128+i for i=3..5. The offset is compared no matter which window carries the write.
- R5: Code 1 (wildcard) tests count every write to the trigger offset, whatever its data or size.
- R6: Code 0 and code 2 tests count a trigger write only when acc_size is 1 and the data is 0xFA.
- R7: A write is ignored, and the count left unchanged, when no test is active or when it goes to any other non-zero offset.
- R8: The descriptor reads little-endian. Byte 0 is the index and byte 1 is 0x01. Bytes 4-7 hold the trigger offset. Byte 8 is the pattern: 0xCE for code 1 and 0xFA otherwise. Bytes 12-15 hold the count. Bytes 2-3 and 9-11 are zero.
- R9: From byte 16 the descriptor holds the name: "mmio" or "portio", a hyphen, then "no-eventfd", "wildcard-eventfd" or "datamatch-eventfd" for codes 0, 1 and 2, then a NUL. The length is 17 plus the name length. A read returns 0 when offset + acc_size is greater than or equal to that length.
- R10: rd_data is updated one cycle after rd_en is sampled and holds its value while rd_en is low.
- R11: notify is high for exactly the cycle after each counted write of a code 1 or code 2 test, and never for code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_sel | input | 1 | 0 = memory window, 1 = I/O window |
| addr | input | ADDR_W (12) | Byte address within the window |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| acc_size | input | SIZE_W (4) | Access size in bytes |
| rd_data | output | 8 | Registered read data |
| notify | output | 1 | One-cycle pulse per counted write of a notifying test |

## Verification
A wrong selection register shows up on the very next descriptor read: byte 0 returns the wrong index, or a zero appears where a live test was expected. It also shows in the cycle after a write, as a notify pulse that is missing or appears when it should not. A counter fault only becomes visible when software reads bytes 12-15, so the bench reads the count back after every group of writes. Faults in the name or length logic only affect bytes near the descriptor's end, so those boundary bytes are read under several access sizes.

// File: rtl/wm_pkg.sv
package wm_pkg;

   localparam int unsigned NUM_CODES = 3;
   localparam int unsigned HDR_BYTES = 16;
   localparam logic [7:0]  PAT_MATCH = 8'hFA;
   localparam logic [7:0]  PAT_ANY   = 8'hCE;
   localparam logic [7:0]  ACC_WIDTH = 8'd1;

   typedef enum logic [1:0] {
      KIND_QUIET = 2'd0,
      KIND_WILD  = 2'd1,
      KIND_MATCH = 2'd2
   } kind_e;

   typedef struct packed {
      logic       act;
      logic       win;
      logic [1:0] code;
   } sel_t;

   localparam logic [8*4-1:0]  WN_MEM   = "mmio";
   localparam logic [8*6-1:0]  WN_IO    = "portio";
   localparam logic [8*10-1:0] KN_QUIET = "no-eventfd";
   localparam logic [8*16-1:0] KN_WILD  = "wildcard-eventfd";
   localparam logic [8*17-1:0] KN_MATCH = "datamatch-eventfd";

   function automatic logic [2:0] test_index(input logic win, input logic [1:0] code);
      return win ? (3'd3 + {1'b0, code}) : {1'b0, code};
   endfunction

   function automatic int kind_len(input logic [1:0] code);
      case (code)
         KIND_QUIET: return 10;
         KIND_WILD:  return 16;
         default:    return 17;
      endcase
   endfunction

   function automatic int name_len(input logic win, input logic [1:0] code);
      return (win ? 6 : 4) + 1 + kind_len(code);
   endfunction

   function automatic logic [7:0] name_byte(input logic win, input logic [1:0] code,
                                            input logic [5:0] k);
      int ki, wl, j;
      logic [7:0] b;
      ki = int'(k);
      wl = win ? 6 : 4;
      b  = 8'h00;
      if (ki < wl) begin
         if (win) b = WN_IO[8*(5-ki) +: 8];
         else     b = WN_MEM[8*(3-ki) +: 8];
      end else if (ki == wl) begin
         b = 8'h2D;
      end else begin
         j = ki - wl - 1;
         if (j < kind_len(code)) begin
            case (code)
               KIND_QUIET: b = KN_QUIET[8*(9-j) +: 8];
               KIND_WILD:  b = KN_WILD[8*(15-j) +: 8];
               default:    b = KN_MATCH[8*(16-j) +: 8];
            endcase
         end
      end
      return b;
   endfunction

endpackage

// File: rtl/wm_sel.sv
module wm_sel
   import wm_pkg::*;
#(
   parameter int ADDR_W = 12
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              win,
   input  logic [ADDR_W-1:0] off,
   input  logic              wr_en,
   input  logic [7:0]        wr_data,
   output sel_t              sel_q,
   output logic              start
);

   logic ctl_wr;
   logic code_ok;

   assign ctl_wr  = wr_en && (off == '0);
   assign code_ok = wr_data < 8'(NUM_CODES);
   assign start   = ctl_wr && code_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
      end else if (ctl_wr) begin
         sel_q.act  <= code_ok;
         sel_q.win  <= win;
         sel_q.code <= wr_data[1:0];
      end
   end

   // R2
   bad_code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && off == '0 && wr_data >= 8'd3) |=> !sel_q.act);

   // R2
   sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && off == '0 && wr_data < 8'd3) |=>
         (sel_q.act && sel_q.code == $past(wr_data[1:0]) && sel_q.win == $past(win)));

endmodule

// File: rtl/wm_count.sv
module wm_count
   import wm_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int SIZE_W    = 4,
   parameter int CNT_W     = 32,
   parameter bit NOTIFY_EN = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  sel_t              sel_q,
   input  logic              start,
   input  logic [ADDR_W-1:0] off,
   input  logic [ADDR_W-1:0] trig,
   input  logic              wr_en,
   input  logic [7:0]        wr_data,
   input  logic [SIZE_W-1:0] acc_size,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              notify
);

   logic is_wild;
   logic gate_ok;
   logic hit;

   assign is_wild = sel_q.code == KIND_WILD;
   assign gate_ok = is_wild || ((acc_size == SIZE_W'(1)) && (wr_data == PAT_MATCH));
   assign hit     = wr_en && sel_q.act && (off != '0) && (off == trig) && gate_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (start) cnt_q <= '0;
      else if (hit)   cnt_q <= cnt_q + CNT_W'(1);
   end

   generate
      if (NOTIFY_EN) begin : g_notify
         logic pulse_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pulse_q <= 1'b0;
            else        pulse_q <= hit && (sel_q.code != KIND_QUIET);
         end
         assign notify = pulse_q;
      end else begin : g_no_notify
         assign notify = 1'b0;
      end
   endgenerate

   // R3
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> cnt_q == '0);

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cnt_q));

   // R5
   wild_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel_q.act && sel_q.code == KIND_WILD && off == trig && off != '0)
         |=> cnt_q == $past(cnt_q) + CNT_W'(1));

   // R6
   size_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && off != '0 && sel_q.code != KIND_WILD && acc_size != SIZE_W'(1))
         |=> $stable(cnt_q));

   // R11
   notify_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      notify |-> ($past(sel_q.act) && $past(sel_q.code) != KIND_QUIET));

endmodule

// File: rtl/wm_desc.sv
module wm_desc
   import wm_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int SIZE_W = 4,
   parameter int CNT_W  = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  sel_t              sel_q,
   input  logic [ADDR_W-1:0] off,
   input  logic [ADDR_W-1:0] trig,
   input  logic              rd_en,
   input  logic [SIZE_W-1:0] acc_size,
   input  logic [CNT_W-1:0]  cnt_q,
   output logic [7:0]        rd_data
);

   localparam int AW1 = ADDR_W + 1;

   logic [AW1-1:0] end_pos;
   logic [AW1-1:0] desc_len;
   logic [31:0]    trig32;
   logic [31:0]    cnt32;
   logic [7:0]     pat;
   logic [7:0]     hdr_b;
   logic [7:0]     byte_d;
   logic [7:0]     rd_q;

   assign end_pos  = {1'b0, off} + AW1'(acc_size);
   assign desc_len = AW1'(HDR_BYTES + 1) + AW1'(name_len(sel_q.win, sel_q.code));
   assign trig32   = 32'(trig);
   assign cnt32    = 32'(cnt_q);
   assign pat      = (sel_q.code == KIND_WILD) ? PAT_ANY : PAT_MATCH;

   always_comb begin
      case (off[3:0])
         4'd0:    hdr_b = {5'd0, test_index(sel_q.win, sel_q.code)};
         4'd1:    hdr_b = ACC_WIDTH;
         4'd4:    hdr_b = trig32[7:0];
         4'd5:    hdr_b = trig32[15:8];
         4'd6:    hdr_b = trig32[23:16];
         4'd7:    hdr_b = trig32[31:24];
         4'd8:    hdr_b = pat;
         4'd12:   hdr_b = cnt32[7:0];
         4'd13:   hdr_b = cnt32[15:8];
         4'd14:   hdr_b = cnt32[23:16];
         4'd15:   hdr_b = cnt32[31:24];
         default: hdr_b = 8'h00;
      endcase
   end

   always_comb begin
      if (!sel_q.act || end_pos >= desc_len)
         byte_d = 8'h00;
      else if (off < ADDR_W'(HDR_BYTES))
         byte_d = hdr_b;
      else
         byte_d = name_byte(sel_q.win, sel_q.code, off[5:0] - 6'd16);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_q <= 8'h00;
      else if (rd_en) rd_q <= byte_d;
   end

   assign rd_data = rd_q;

   // R1
   idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !sel_q.act) |=> rd_data == 8'h00);

   // R10
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   // R9
   tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && end_pos >= desc_len) |=> rd_data == 8'h00);

endmodule

// File: rtl/wmatch_ctr.sv
module wmatch_ctr
   import wm_pkg::*;
#(
   parameter int ADDR_W        = 12,
   parameter int SIZE_W        = 4,
   parameter int CNT_W         = 32,
   parameter int MEM_SPAN_LOG2 = 12,
   parameter int IO_SPAN_LOG2  = 8,
   parameter int MEM_BASE      = 2048,
   parameter int IO_BASE       = 128,
   parameter bit NOTIFY_EN     = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              win_sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [7:0]        wr_data,
   input  logic              rd_en,
   input  logic [SIZE_W-1:0] acc_size,
   output logic [7:0]        rd_data,
   output logic              notify
);

   localparam logic [ADDR_W-1:0] MEM_MASK = ADDR_W'((64'd1 << MEM_SPAN_LOG2) - 64'd1);
   localparam logic [ADDR_W-1:0] IO_MASK  = ADDR_W'((64'd1 << IO_SPAN_LOG2) - 64'd1);

   generate
      if (MEM_SPAN_LOG2 > ADDR_W || IO_SPAN_LOG2 > ADDR_W) begin : g_bad_span
         $error("window span wider than address");
      end
      if (MEM_BASE < 1 || MEM_BASE + 3 > (1 << MEM_SPAN_LOG2)) begin : g_bad_mem_base
         $error("memory trigger offsets leave the memory window");
      end
      if (IO_BASE < 1 || IO_BASE + 6 > (1 << IO_SPAN_LOG2)) begin : g_bad_io_base
         $error("I/O trigger offsets leave the I/O window");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("counter width must be 1 to 32");
      end
      if (SIZE_W > ADDR_W || ADDR_W < 6) begin : g_bad_size
         $error("size or address width out of range");
      end
   endgenerate

   logic [ADDR_W-1:0] off;
   logic [ADDR_W-1:0] trig;
   logic [2:0]        idx;
   sel_t              sel_q;
   logic              start;
   logic [CNT_W-1:0]  cnt_q;

   assign off  = addr & (win_sel ? IO_MASK : MEM_MASK);
   assign idx  = test_index(sel_q.win, sel_q.code);
   assign trig = (sel_q.win ? ADDR_W'(IO_BASE) : ADDR_W'(MEM_BASE)) + ADDR_W'(idx);

   wm_sel #(.ADDR_W(ADDR_W)) u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .win     (win_sel),
      .off     (off),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .sel_q   (sel_q),
      .start   (start)
   );

   wm_count #(
      .ADDR_W    (ADDR_W),
      .SIZE_W    (SIZE_W),
      .CNT_W     (CNT_W),
      .NOTIFY_EN (NOTIFY_EN)
   ) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_q    (sel_q),
      .start    (start),
      .off      (off),
      .trig     (trig),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .acc_size (acc_size),
      .cnt_q    (cnt_q),
      .notify   (notify)
   );

   wm_desc #(
      .ADDR_W (ADDR_W),
      .SIZE_W (SIZE_W),
      .CNT_W  (CNT_W)
   ) u_desc (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_q    (sel_q),
      .off      (off),
      .trig     (trig),
      .rd_en    (rd_en),
      .acc_size (acc_size),
      .cnt_q    (cnt_q),
      .rd_data  (rd_data)
   );

   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> !notify);

   // R11
   notify_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (notify && !wr_en) |=> !notify);

endmodule

// File: tb/sim_wmatch_ctr.sv
module sim_wmatch_ctr;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        win_sel = 1'b0;
   logic [11:0] addr = '0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        rd_en = 1'b0;
   logic [3:0]  acc_size = 4'd1;
   logic [7:0]  rd_data;
   logic        notify;

   always #2 clk = ~clk;

   wmatch_ctr u0 (
      .clk(clk), .rst_n(rst_n), .win_sel(win_sel), .addr(addr),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .acc_size(acc_size),
      .rd_data(rd_data), .notify(notify)
   );

   typedef struct {
      logic [7:0] val;
      string      tag;
   } exp_t;

   exp_t        exp_q[$];
   int          n_chk = 0;
   int          n_err = 0;
   logic        rd_seen = 1'b0;
   logic [7:0]  last_exp = 8'h00;

   string nm[6] = '{"mmio-no-eventfd", "mmio-wildcard-eventfd", "mmio-datamatch-eventfd",
                    "portio-no-eventfd", "portio-wildcard-eventfd", "portio-datamatch-eventfd"};

   bit          m_act = 0;
   bit          m_win = 0;
   int          m_code = 0;
   int unsigned m_cnt = 0;

   function automatic void check(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endfunction

   function automatic int offset_of(bit win, int a);
      return win ? (a & 255) : (a & 4095);
   endfunction

   function automatic logic [7:0] exp_byte(bit win, int a, int size);
      int off, idx, len, trig;
      string n;
      off = offset_of(win, a);
      if (!m_act) return 8'h00;
      idx  = (m_win ? 3 : 0) + m_code;
      n    = nm[idx];
      len  = 17 + n.len();
      trig = (m_win ? 128 : 2048) + idx;
      if (off + size >= len) return 8'h00;
      if (off == 0) return 8'(idx);
      if (off == 1) return 8'h01;
      if (off >= 4 && off <= 7) return 8'(trig >> (8 * (off - 4)));
      if (off == 8) return (m_code == 1) ? 8'hCE : 8'hFA;
      if (off >= 12 && off <= 15) return 8'(m_cnt >> (8 * (off - 12)));
      if (off >= 16 && (off - 16) < n.len()) return n[off - 16];
      return 8'h00;
   endfunction

   always @(posedge clk) rd_seen <= rd_en;

   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "scoreboard underflow", 0, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(rd_data == e.val, e.tag, int'(rd_data), int'(e.val));
         end
      end
   end

   task automatic rd_op(bit win, int a, int size, string tag);
      exp_t e;
      @(negedge clk);
      win_sel  = win;
      addr     = 12'(a);
      acc_size = 4'(size);
      rd_en    = 1'b1;
      e.val    = exp_byte(win, a, size);
      e.tag    = tag;
      last_exp = e.val;
      exp_q.push_back(e);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic wr_op(bit win, int a, logic [7:0] d, int size, string tag);
      int off, trig;
      bit exp_nt;
      off    = offset_of(win, a);
      exp_nt = 0;
      trig   = (m_win ? 128 : 2048) + (m_win ? 3 : 0) + m_code;
      if (off == 0) begin
         m_act  = d < 8'd3;
         m_win  = win;
         m_code = int'(d[1:0]);
         m_cnt  = 0;
      end else if (m_act && off == trig && (m_code == 1 || (size == 1 && d == 8'hFA))) begin
         m_cnt++;
         exp_nt = (m_code != 0);
      end
      @(negedge clk);
      win_sel  = win;
      addr     = 12'(a);
      wr_data  = d;
      acc_size = 4'(size);
      wr_en    = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      check(notify == exp_nt, {"R11 notify after ", tag}, int'(notify), int'(exp_nt));
   endtask

   task automatic read_count(bit win, string tag);
      for (int k = 12; k < 16; k++) rd_op(win, k, 1, tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      m_act = 0;
      m_cnt = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(4 * 150000);
      check(1'b0, "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      do_reset();
      // R1: idle after reset
      check(notify == 1'b0, "R1 notify after reset", int'(notify), 0);
      rd_op(0, 0, 1, "R1 read idle mem");
      rd_op(1, 8, 1, "R1 read idle io");

      // R7: writes with no active test
      wr_op(0, 2049, 8'hFA, 1, "R7 write while idle");

      // R2, R8, R9: select memory wildcard test, dump descriptor
      wr_op(0, 0, 8'd1, 1, "R2 select mem code 1");
      for (int k = 0; k < 44; k++) rd_op(0, k, 1, "R8 R9 descriptor mmio wildcard");

      // R5: wildcard counts any data and size
      wr_op(0, 2049, 8'h00, 1, "R5 wild data 00");
      wr_op(0, 2049, 8'h5A, 4, "R5 wild size 4");
      wr_op(0, 2049, 8'hFA, 2, "R5 wild size 2");
      // R7: other offset ignored
      wr_op(0, 2048, 8'hFA, 1, "R7 off-trigger");
      wr_op(0, 7, 8'h33, 1, "R7 other offset");
      read_count(0, "R5 R7 count mmio wildcard");

      // R10: read data held while rd_en low
      rd_op(0, 12, 1, "R10 count byte");
      repeat (3) @(negedge clk);
      check(rd_data == last_exp, "R10 hold", int'(rd_data), int'(last_exp));

      // R3, R6: switch to memory data-match
      wr_op(0, 0, 8'd2, 1, "R2 select mem code 2");
      read_count(0, "R3 cleared on start");
      wr_op(0, 2050, 8'hFA, 1, "R6 match ok");
      wr_op(0, 2050, 8'hFA, 2, "R6 wrong size");
      wr_op(0, 2050, 8'h11, 1, "R6 wrong data");
      wr_op(0, 2050, 8'hFA, 1, "R6 match ok again");
      read_count(0, "R6 count mmio datamatch");
      for (int k = 16; k < 40; k++) rd_op(0, k, 1, "R9 name mmio datamatch");

      // R4, R11: I/O quiet test, trigger 131
      wr_op(1, 0, 8'd0, 1, "R2 select io code 0");
      rd_op(1, 0, 1, "R2 index io code 0");
      wr_op(1, 131, 8'hFA, 1, "R11 quiet counted no notify");
      wr_op(0, 131, 8'hFA, 1, "R4 trigger via mem window");
      wr_op(1, 12'h183, 8'hFA, 1, "R4 io address masked");
      wr_op(1, 131, 8'hCE, 1, "R6 quiet wrong data");
      read_count(1, "R4 count io quiet");

      // R2: out-of-range code leaves idle
      wr_op(1, 0, 8'd3, 1, "R2 code 3");
      rd_op(1, 0, 1, "R2 idle after code 3");
      rd_op(0, 12, 1, "R2 idle count read");
      wr_op(1, 131, 8'hFA, 1, "R7 idle write");

      // R9: length boundary on I/O data-match (len 41)
      wr_op(1, 0, 8'd2, 1, "R2 select io code 2");
      rd_op(1, 39, 1, "R9 last name byte");
      rd_op(1, 40, 1, "R9 NUL boundary");
      rd_op(1, 38, 2, "R9 size 2 in range");
      rd_op(1, 39, 2, "R9 size 2 at end");
      rd_op(1, 4, 1, "R8 trigger low byte io");
      rd_op(1, 8, 1, "R8 pattern io match");
      wr_op(1, 133, 8'hFA, 1, "R11 io match notify");
      read_count(1, "R6 count io datamatch");

      // R1: reset during active test
      do_reset();
      rd_op(1, 0, 1, "R1 idle after second reset");
      rd_op(0, 12, 1, "R1 count idle");

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule